// File: doc/BRIEF.md
# Subcode R-W Capture Interface

This block sits between a disc DSP and the graphics decoding path. For each subcode frame the DSP marks the frame with a frame-sync line and, on the two sync frames that open a 98-frame block, a block-sync line. The block checks whether the frame is valid by looking at the sync lines a fixed number of system clocks after the sync edge. If the frame passes, the block drives a short burst of readout clocks back to the DSP and shifts in one serial bit on each clock.

A two-bit mode input selects one of three DSP conventions. Mode `00` qualifies on the rising frame-sync edge and samples on the falling readout-clock edge. Mode `11` uses the same qualification but inverts the readout clock, so samples are taken on its rising edge. Mode `10` qualifies on the falling frame-sync edge and ignores block sync. Code `01` is unused and keeps the block quiet. A mute input stops everything at once.

Each burst has seven pulses. The first pulse carries the P/Q bit, which is dropped. The remaining six pulses form the R..W symbol, which is presented with a one-cycle strobe. A block-start flag marks the first symbol after block sync was seen, so that a downstream packet assembler can find the start of the 98-frame block. The timing counts are parameters. Their defaults suit a 14.31818 MHz system clock: about 2.2 µs to the qualification point, about 4.9 µs to the first clock, and a readout clock of about 224 kHz.

Top module: `subcode_rw_capture`

## Requirements
- R1: In modes `00` and `11`, a rising `fsync_i` edge starts a frame. The frame qualifies only if, QUAL_DLY (32) clocks after the edge is first seen, `fsync_i` is high and `bsync_i` is low. A frame that does not qualify produces no readout-clock pulse.
- R2: In mode `10`, a falling `fsync_i` edge starts a frame. The frame qualifies only if `fsync_i` is still low QUAL_DLY clocks later. `bsync_i` has no effect on qualification in this mode.
- R3: Mode code `01` starts no frame. It produces no readout-clock pulse and no symbol.
- R4: A qualified frame produces exactly seven readout-clock pulses. Each pulse stays at its active level for HALF_PER (32) clocks and is followed by HALF_PER clocks at the idle level, giving a period of 64 clocks.
- R5: The readout clock first leaves its idle level START_DLY (70) clocks after the clock edge on which the sync transition is first seen.
- R6: In modes `00`, `01` and `10`, `rdclk_o` idles low, pulses high, and samples on its falling edge. In mode `11` it idles high, pulses low, and samples on its rising edge.
- R7: `sdata_i` is captured on every sampling edge. The first captured bit is discarded. `sym_o[5]` holds the second captured bit (R) and `sym_o[0]` holds the seventh (W). `sym_valid_o` is high for exactly one cycle, starting right after the seventh sampling edge, and `sym_o` holds its value between strobes.
- R8: In modes `00` and `11`, if `bsync_i` is seen high while mute is low, the next symbol strobe carries `blk_start_o = 1`. After that the flag clears. In mode `10`, `blk_start_o` stays 0.
- R9: While `mute_i` is high, no frame starts and `bsync_i` is ignored. If mute rises during a burst, the readout clock returns to idle at the next edge and the frame ends without a symbol.
- R10: During and right after reset, `sym_valid_o`, `blk_start_o` and `sym_o` are 0 and `rdclk_o` is at the idle level of the selected mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync_i | input | 1 | Subcode frame sync from the DSP |
| bsync_i | input | 1 | Subcode block sync from the DSP |
| sdata_i | input | 1 | Serial subcode data from the DSP |
| mute_i | input | 1 | High: ignore inputs and stop the readout clock |
| mode_i | input | 2 | Interface convention select (`00`, `10`, `11`) |
| rdclk_o | output | 1 | Readout clock burst to the DSP |
| sym_o | output | SYM_W (6) | Captured R..W symbol, R in the MSB |
| sym_valid_o | output | 1 | One-cycle strobe marking a new symbol |
| blk_start_o | output | 1 | Marks the symbol that follows a block sync |

## Verification
The assertions take several things for granted about the inputs:
- All inputs are synchronous to `clk`.
- `mode_i` changes only between frames.
- Sync edges are spaced further apart than one complete burst, so a new edge never arrives while a burst is running.

The stimulus drives every input at the falling clock edge. It changes the mode only while the block is idle, and it places each frame in its own window of over 600 clocks. Serial data is updated only right after each observed sampling edge, which leaves 63 clocks of setup before the next sample.

// File: rtl/subcode_pkg.sv
package subcode_pkg;

  // Interface conventions selected by mode_i
  typedef enum logic [1:0] {
    IFM_RISE_NORM = 2'b00,
    IFM_UNUSED    = 2'b01,
    IFM_FALL      = 2'b10,
    IFM_RISE_INV  = 2'b11
  } if_mode_e;

  // Frame qualifier sequence
  typedef enum logic [1:0] {
    QS_IDLE  = 2'b00,
    QS_WAIT  = 2'b01,
    QS_LEAD  = 2'b10,
    QS_BURST = 2'b11
  } qual_state_e;

  function automatic logic mode_rising(input logic [1:0] m);
    return (m == IFM_RISE_NORM) || (m == IFM_RISE_INV);
  endfunction

endpackage

// File: rtl/subcode_frame_qual.sv
module subcode_frame_qual
  import subcode_pkg::*;
#(
  parameter int unsigned QUAL_DLY  = 32,
  parameter int unsigned START_DLY = 70
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fsync_i,
  input  logic       bsync_i,
  input  logic       mute_i,
  input  logic [1:0] mode_i,
  input  logic       burst_done_i,
  output logic       go_o
);

  localparam int unsigned CNT_W = $clog2(START_DLY);
  localparam logic [CNT_W-1:0] QUAL_LAST  = CNT_W'(QUAL_DLY - 1);
  localparam logic [CNT_W-1:0] START_LAST = CNT_W'(START_DLY - 1);

  qual_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             fs_q;
  logic             edge_seen;
  logic             qual_ok;

  // Edge selection per mode; the unused code selects no edge
  always_comb begin
    edge_seen = 1'b0;
    qual_ok   = 1'b0;
    if (mode_rising(mode_i)) begin
      edge_seen = fsync_i && !fs_q;
      qual_ok   = fsync_i && !bsync_i;
    end else if (mode_i == IFM_FALL) begin
      edge_seen = !fsync_i && fs_q;
      qual_ok   = !fsync_i;
    end
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    go_o    = 1'b0;
    unique case (state_q)
      QS_IDLE: begin
        cnt_d = '0;
        if (edge_seen && !mute_i) state_d = QS_WAIT;
      end
      QS_WAIT: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == QUAL_LAST) state_d = qual_ok ? QS_LEAD : QS_IDLE;
      end
      QS_LEAD: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == START_LAST) begin
          go_o    = 1'b1;
          state_d = QS_BURST;
        end
      end
      QS_BURST: begin
        if (burst_done_i) state_d = QS_IDLE;
      end
      default: state_d = QS_IDLE;
    endcase
    if (mute_i) state_d = QS_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q    <= 1'b0;
      state_q <= QS_IDLE;
      cnt_q   <= '0;
    end else begin
      fs_q    <= fsync_i;
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  AST_NO_START_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == QS_IDLE && mute_i) |=> (state_q == QS_IDLE)); // R9

  AST_UNUSED_MODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == QS_IDLE && mode_i == IFM_UNUSED) |=> (state_q == QS_IDLE)); // R3

  AST_LEAD_FROM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == QS_LEAD) |-> ($past(state_q) == QS_WAIT || $past(state_q) == QS_LEAD)); // R1

endmodule

// File: rtl/subcode_burst_clk.sv
module subcode_burst_clk #(
  parameter int unsigned HALF_PER = 32,
  parameter int unsigned NPULSE   = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  input  logic abort_i,
  output logic hi_o,
  output logic sample_o,
  output logic last_o
);

  localparam int unsigned HW = (HALF_PER > 1) ? $clog2(HALF_PER) : 1;
  localparam int unsigned IW = $clog2(NPULSE + 1);
  localparam logic [HW-1:0] HALF_LAST = HW'(HALF_PER - 1);
  localparam logic [IW-1:0] IDX_LAST  = IW'(NPULSE - 1);

  logic          on_q, on_d;
  logic          hi_q, hi_d;
  logic [HW-1:0] hcnt_q, hcnt_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          phase_end;
  logic          st_en;

  assign phase_end = on_q && (hcnt_q == HALF_LAST);
  assign sample_o  = phase_end && hi_q && !abort_i;
  assign last_o    = sample_o && (idx_q == IDX_LAST);
  assign hi_o      = hi_q;
  assign st_en     = abort_i || go_i || on_q;

  always_comb begin
    on_d   = on_q;
    hi_d   = hi_q;
    hcnt_d = hcnt_q;
    idx_d  = idx_q;
    if (abort_i) begin
      on_d   = 1'b0;
      hi_d   = 1'b0;
      hcnt_d = '0;
      idx_d  = '0;
    end else if (go_i) begin
      on_d   = 1'b1;
      hi_d   = 1'b1;
      hcnt_d = '0;
      idx_d  = '0;
    end else if (on_q) begin
      if (phase_end) begin
        hcnt_d = '0;
        if (hi_q) begin
          hi_d = 1'b0;
          if (idx_q == IDX_LAST) on_d = 1'b0;
        end else begin
          hi_d  = 1'b1;
          idx_d = idx_q + 1'b1;
        end
      end else begin
        hcnt_d = hcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q   <= 1'b0;
      hi_q   <= 1'b0;
      hcnt_q <= '0;
      idx_q  <= '0;
    end else if (st_en) begin
      on_q   <= on_d;
      hi_q   <= hi_d;
      hcnt_q <= hcnt_d;
      idx_q  <= idx_d;
    end
  end

  AST_MUTE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (!on_q && !hi_q)); // R9

  AST_GO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |-> !on_q); // R4

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    on_q |-> (idx_q <= IDX_LAST)); // R4

  AST_ACTIVE_INSIDE_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    hi_q |-> on_q); // R6

endmodule

// File: rtl/subcode_sym_shift.sv
module subcode_sym_shift #(
  parameter int unsigned SYM_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_i,
  input  logic             last_i,
  input  logic             sdata_i,
  input  logic             bsync_i,
  input  logic             mute_i,
  input  logic             track_blk_i,
  output logic [SYM_W-1:0] sym_o,
  output logic             valid_o,
  output logic             blk_o
);

  logic [SYM_W-1:0] sh_q, sh_d;
  logic [SYM_W-1:0] sym_q;
  logic             valid_q, blk_q;
  logic             pend_q, pend_d;
  logic             pend_set;

  // Oldest bit falls off the top after SYM_W+1 shifts
  assign sh_d     = {sh_q[SYM_W-2:0], sdata_i};
  assign pend_set = bsync_i && !mute_i && track_blk_i;

  always_comb begin
    pend_d = pend_q;
    if (last_i)   pend_d = 1'b0;
    if (pend_set) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else if (sample_i) sh_q <= sh_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sym_q <= '0;
    else if (last_i) sym_q <= sh_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      blk_q   <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      valid_q <= last_i;
      blk_q   <= last_i && pend_q;
      pend_q  <= pend_d;
    end
  end

  assign sym_o   = sym_q;
  assign valid_o = valid_q;
  assign blk_o   = blk_q;

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q); // R7

  AST_SYM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !last_i |=> $stable(sym_q)); // R7

  AST_BLK_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    blk_q |-> valid_q); // R8

endmodule

// File: rtl/subcode_rw_capture.sv
module subcode_rw_capture
  import subcode_pkg::*;
#(
  parameter int unsigned QUAL_DLY  = 32,
  parameter int unsigned START_DLY = 70,
  parameter int unsigned HALF_PER  = 32,
  parameter int unsigned SYM_W     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fsync_i,
  input  logic             bsync_i,
  input  logic             sdata_i,
  input  logic             mute_i,
  input  logic [1:0]       mode_i,
  output logic             rdclk_o,
  output logic [SYM_W-1:0] sym_o,
  output logic             sym_valid_o,
  output logic             blk_start_o
);

  localparam int unsigned NPULSE = SYM_W + 1;

  logic rst_meta_q, rst_sync_q;
  logic go, hi, sample, last;
  logic inv_pol, track_blk;

  // Reset asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign inv_pol   = (mode_i == IFM_RISE_INV);
  assign track_blk = mode_rising(mode_i);

  subcode_frame_qual #(
    .QUAL_DLY  (QUAL_DLY),
    .START_DLY (START_DLY)
  ) u_qual (
    .clk          (clk),
    .rst_n        (rst_sync_q),
    .fsync_i      (fsync_i),
    .bsync_i      (bsync_i),
    .mute_i       (mute_i),
    .mode_i       (mode_i),
    .burst_done_i (last),
    .go_o         (go)
  );

  subcode_burst_clk #(
    .HALF_PER (HALF_PER),
    .NPULSE   (NPULSE)
  ) u_clk (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .go_i     (go),
    .abort_i  (mute_i),
    .hi_o     (hi),
    .sample_o (sample),
    .last_o   (last)
  );

  subcode_sym_shift #(
    .SYM_W (SYM_W)
  ) u_shift (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .sample_i    (sample),
    .last_i      (last),
    .sdata_i     (sdata_i),
    .bsync_i     (bsync_i),
    .mute_i      (mute_i),
    .track_blk_i (track_blk),
    .sym_o       (sym_o),
    .valid_o     (sym_valid_o),
    .blk_o       (blk_start_o)
  );

  assign rdclk_o = hi ^ inv_pol;

  AST_UNUSED_NO_SYMBOL: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (mode_i == IFM_UNUSED && !hi) |=> !hi); // R3

  AST_FALL_NO_BLOCK: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (mode_i == IFM_FALL && $past(mode_i) == IFM_FALL) |-> !blk_start_o); // R8

endmodule

// File: tb/subcode_rw_capture_tb.sv
`timescale 1ns/1ps
module subcode_rw_capture_tb_top;

  localparam int QD = 32;
  localparam int SD = 70;
  localparam int HP = 32;

  logic       clk;
  logic       rst_n;
  logic       fsync_i, bsync_i, sdata_i, mute_i;
  logic [1:0] mode_i;
  logic       rdclk_o;
  logic [5:0] sym_o;
  logic       sym_valid_o, blk_start_o;

  int total = 0;
  int bad   = 0;

  // Fields: mode[15:14] variant[13:12] bits[11:5] pulses[4:1] blk[0]
  // variant 0 good, 1 sync level lost before qualification, 2 bsync high
  localparam logic [15:0] VEC [12] = '{
    {2'b00, 2'd0, 7'h55, 4'd7, 1'b0},
    {2'b00, 2'd2, 7'h11, 4'd0, 1'b0},
    {2'b00, 2'd0, 7'h2A, 4'd7, 1'b1},
    {2'b00, 2'd1, 7'h33, 4'd0, 1'b0},
    {2'b10, 2'd0, 7'h7F, 4'd7, 1'b0},
    {2'b10, 2'd1, 7'h0F, 4'd0, 1'b0},
    {2'b10, 2'd2, 7'h5A, 4'd7, 1'b0},
    {2'b11, 2'd0, 7'h13, 4'd7, 1'b0},
    {2'b11, 2'd2, 7'h44, 4'd0, 1'b0},
    {2'b11, 2'd0, 7'h6C, 4'd7, 1'b1},
    {2'b01, 2'd0, 7'h3C, 4'd0, 1'b0},
    {2'b00, 2'd0, 7'h00, 4'd7, 1'b0}
  };

  subcode_rw_capture dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .fsync_i     (fsync_i),
    .bsync_i     (bsync_i),
    .sdata_i     (sdata_i),
    .mute_i      (mute_i),
    .mode_i      (mode_i),
    .rdclk_o     (rdclk_o),
    .sym_o       (sym_o),
    .sym_valid_o (sym_valid_o),
    .blk_start_o (blk_start_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input logic ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic string mode_req(input logic [1:0] m);
    if (m == 2'b10) return "R2";
    if (m == 2'b01) return "R3";
    return "R1";
  endfunction

  task automatic run_frame(input logic [1:0] m, input int var_k,
                           input logic [6:0] bits, input int exp_n,
                           input logic exp_blk);
    logic idle_lvl, fs_idle, prev, cur, got_blk;
    logic [5:0] got_sym;
    int n_edges, nval, first_at, first_smp, last_smp, bit_i;
    idle_lvl = (m == 2'b11);
    fs_idle  = (m == 2'b10);
    @(negedge clk);
    mode_i  = m;
    fsync_i = fs_idle;
    bsync_i = 1'b0;
    sdata_i = bits[6];
    repeat (5) @(negedge clk);
    chk(rdclk_o === idle_lvl, "R6", "idle level before frame", rdclk_o, idle_lvl);
    fsync_i = ~fs_idle;
    bsync_i = (var_k == 2);
    n_edges = 0; nval = 0; first_at = -1; first_smp = -1; last_smp = -1;
    bit_i = 5; prev = rdclk_o; got_sym = '0; got_blk = 1'b0;
    for (int k = 1; k <= 620; k++) begin
      @(negedge clk);
      if (k == 10 && var_k == 1) fsync_i = fs_idle;
      if (k == 40) begin
        fsync_i = fs_idle;
        bsync_i = 1'b0;
      end
      cur = rdclk_o;
      if (first_at < 0 && cur !== idle_lvl) first_at = k;
      if (prev !== idle_lvl && cur === idle_lvl) begin
        n_edges++;
        if (first_smp < 0) first_smp = k;
        last_smp = k;
        if (bit_i >= 0) sdata_i = bits[bit_i];
        bit_i--;
      end
      if (sym_valid_o) begin
        nval++;
        got_sym = sym_o;
        got_blk = blk_start_o;
      end
      prev = cur;
    end
    chk(n_edges == exp_n, mode_req(m), "pulse count", n_edges, exp_n);
    chk(nval == ((exp_n > 0) ? 1 : 0), "R7", "strobe count", nval, (exp_n > 0) ? 1 : 0);
    chk(rdclk_o === idle_lvl, "R6", "idle level after frame", rdclk_o, idle_lvl);
    if (exp_n > 0) begin
      chk(first_at == SD + 1, "R5", "first edge delay", first_at, SD + 1);
      chk(first_smp - first_at == HP, "R4", "active width", first_smp - first_at, HP);
      chk(last_smp - first_smp == 6 * 2 * HP, "R4", "pulse period", last_smp - first_smp, 6 * 2 * HP);
      chk(got_sym == bits[5:0], "R7", "symbol", got_sym, bits[5:0]);
      chk(got_blk == exp_blk, "R8", "block flag", got_blk, exp_blk);
    end
  endtask

  initial begin
    rst_n = 1'b0; fsync_i = 1'b0; bsync_i = 1'b0; sdata_i = 1'b0;
    mute_i = 1'b0; mode_i = 2'b00;
    repeat (4) @(negedge clk);
    // R10: reset state
    chk(rdclk_o === 1'b0, "R10", "rdclk in reset", rdclk_o, 0);
    chk(sym_valid_o === 1'b0, "R10", "valid in reset", sym_valid_o, 0);
    chk(blk_start_o === 1'b0, "R10", "block flag in reset", blk_start_o, 0);
    chk(sym_o === 6'd0, "R10", "symbol in reset", sym_o, 0);
    mode_i = 2'b11;
    @(negedge clk);
    chk(rdclk_o === 1'b1, "R10", "inverted idle in reset", rdclk_o, 1);
    mode_i = 2'b00;
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    for (int i = 0; i < 12; i++) begin
      run_frame(VEC[i][15:14], int'(VEC[i][13:12]), VEC[i][11:5],
                int'(VEC[i][4:1]), VEC[i][0]);
    end

    // R9: mute during the fourth active phase aborts the frame
    begin
      int nval;
      int act_after;
      @(negedge clk);
      mode_i = 2'b00; fsync_i = 1'b0; bsync_i = 1'b0; sdata_i = 1'b1;
      repeat (5) @(negedge clk);
      fsync_i = 1'b1;
      nval = 0; act_after = 0;
      for (int k = 1; k <= 620; k++) begin
        @(negedge clk);
        if (k == 40) fsync_i = 1'b0;
        if (k == 268) begin
          chk(rdclk_o === 1'b1, "R9", "pulse active before mute", rdclk_o, 1);
          mute_i = 1'b1;
        end
        if (k == 269) chk(rdclk_o === 1'b0, "R9", "clock stops at mute", rdclk_o, 0);
        if (k > 269 && rdclk_o !== 1'b0) act_after++;
        if (sym_valid_o) nval++;
      end
      chk(nval == 0, "R9", "no symbol after abort", nval, 0);
      chk(act_after == 0, "R9", "clock stays stopped", act_after, 0);
    end

    // R9: while muted no frame starts and bsync is ignored
    begin
      int act;
      act = 0;
      @(negedge clk);
      bsync_i = 1'b1;
      fsync_i = 1'b1;
      for (int k = 1; k <= 200; k++) begin
        @(negedge clk);
        if (k == 50) begin
          fsync_i = 1'b0;
          bsync_i = 1'b0;
        end
        if (rdclk_o !== 1'b0 || sym_valid_o) act++;
      end
      chk(act == 0, "R9", "activity while muted", act, 0);
      mute_i = 1'b0;
      run_frame(2'b00, 0, 7'h4B, 7, 1'b0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule